// File: doc/BRIEF.md
# Pad Output Sleep Retention

This block sits between the output routing stage of a chip and its pads. For every pad it receives the live output data and output enable that the routing stage has chosen. It forwards them unchanged while the chip is awake. Each pad also carries a small sleep configuration: an enable bit and a two-bit behaviour code. When the power manager pulses the global sleep trigger, every pad whose sleep enable is set switches to its configured behaviour in the same clock cycle. That behaviour is tie low, tie high, high impedance, or holding the values that were live at the trigger.

Leaving sleep is done one pad at a time. The trigger sets a per-pad sleep state bit, and that bit stays set until software pulses the clear input for that pad. Software can therefore release each output only after its peripheral has been re-initialised. Configuration arrives as plain data with per-pad write strobes. A per-pad lock freezes a pad's sleep configuration until the next reset.

Top module: `pad_sleep_retention`

## Requirements
- R1: After a synchronous reset, every sleep state bit is 0, every sleep enable is 0, every lock is open, and each pad output equals its live data and enable.
- R2: A pad whose sleep enable is 0 when the trigger is sampled keeps its sleep state at 0 and continues to pass its live data and enable.
- R3: A sleeping pad with behaviour code 0 (tie low) drives data 0 with output enable 1.
- R4: A sleeping pad with behaviour code 1 (tie high) drives data 1 with output enable 1.
- R5: A sleeping pad with behaviour code 2 (high impedance) drives output enable 0 and data 0.
- R6: A sleeping pad with behaviour code 3 (hold) drives the live data and enable that were sampled at the clock edge where the trigger was taken, regardless of later live changes.
- R7: A single trigger cycle sets the sleep state of all sleep-enabled pads at the same edge, and the sleep behaviour is visible on the outputs right after that edge.
- R8: A pad's sleep state stays set until its own clear strobe is sampled. After that edge the pad passes live values again, and the other pads are unaffected.
- R9: A clear strobe sampled at the same edge as a trigger, on a sleep-enabled pad, leaves that pad's sleep state set.
- R10: After a pad's lock strobe is sampled, later configuration writes to that pad have no effect until reset.
- R11: A trigger that arrives while a pad is already asleep does not recapture that pad's held values.
- R12: A configuration write sampled at an edge governs triggers from the next edge on. A trigger taken at the same edge as a write uses the earlier configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| live_dout_i | input | NUM_PADS | Live output data per pad from the routing stage |
| live_doe_i | input | NUM_PADS | Live output enable per pad from the routing stage |
| cfg_wr_i | input | NUM_PADS | Per-pad configuration write strobe |
| cfg_sleep_en_i | input | 1 | Sleep enable value written to strobed pads |
| cfg_mode_i | input | 2 | Behaviour code written to strobed pads (0 low, 1 high, 2 high-Z, 3 hold) |
| cfg_lock_i | input | NUM_PADS | Per-pad lock strobe; freezes that pad's configuration until reset |
| sleep_trig_i | input | 1 | Global sleep entry trigger from the power manager |
| sleep_clr_i | input | NUM_PADS | Per-pad software clear of the sleep state |
| pad_dout_o | output | NUM_PADS | Final output data per pad |
| pad_doe_o | output | NUM_PADS | Final output enable per pad |
| sleep_state_o | output | NUM_PADS | Per-pad sleep state |

## Verification
The bench builds the block with five pads. That is enough to give one pad each of the four behaviour codes and leave a fifth with sleep disabled, all under one shared trigger. The directed phase uses that layout to cover a trigger colliding with a clear and a trigger colliding with a configuration write. It also covers re-triggering a pad that is already asleep and writing to a locked pad. The random phase then mixes writes, locks, triggers and clears across all five pads, with a reset in the middle that reopens every lock.

// File: rtl/pad_sleep_pkg.sv
package pad_sleep_pkg;

    localparam int unsigned MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        SLP_TIE_LO = 2'd0,
        SLP_TIE_HI = 2'd1,
        SLP_HIGHZ  = 2'd2,
        SLP_HOLD   = 2'd3
    } sleep_mode_e;

    typedef struct packed {
        logic        en;
        sleep_mode_e mode;
    } pad_sleep_cfg_t;

    typedef struct packed {
        logic d;
        logic oe;
    } pad_drv_t;

    localparam pad_sleep_cfg_t CFG_RESET = '{en: 1'b0, mode: SLP_TIE_LO};

    function automatic pad_drv_t sleep_drive(input sleep_mode_e mode,
                                             input pad_drv_t    held);
        pad_drv_t r;
        unique case (mode)
            SLP_TIE_LO: r = '{d: 1'b0, oe: 1'b1};
            SLP_TIE_HI: r = '{d: 1'b1, oe: 1'b1};
            SLP_HIGHZ:  r = '{d: 1'b0, oe: 1'b0};
            default:    r = held;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pad_sleep_cfg.sv
module pad_sleep_cfg
    import pad_sleep_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           wr_i,
    input  pad_sleep_cfg_t wdata_i,
    input  logic           lock_i,
    output pad_sleep_cfg_t cfg_o,
    output logic           open_o
);

    pad_sleep_cfg_t cfg_q;
    logic           open_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q  <= CFG_RESET;
            open_q <= 1'b1;
        end else begin
            if (wr_i && open_q) begin
                cfg_q <= wdata_i;
            end
            if (lock_i) begin
                open_q <= 1'b0;
            end
        end
    end

    assign cfg_o  = cfg_q;
    assign open_o = open_q;

endmodule

// File: rtl/pad_sleep_track.sv
module pad_sleep_track
    import pad_sleep_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     trig_i,
    input  logic     en_i,
    input  logic     clr_i,
    input  pad_drv_t live_i,
    output logic     asleep_o,
    output pad_drv_t held_o
);

    logic     asleep_q;
    pad_drv_t held_q;
    logic     enter;
    logic     capture;

    assign enter   = trig_i && en_i;
    assign capture = enter && !asleep_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            asleep_q <= 1'b0;
            held_q   <= '0;
        end else begin
            asleep_q <= enter || (asleep_q && !clr_i);
            if (capture) begin
                held_q <= live_i;
            end
        end
    end

    assign asleep_o = asleep_q;
    assign held_o   = held_q;

endmodule

// File: rtl/pad_sleep_drive.sv
module pad_sleep_drive
    import pad_sleep_pkg::*;
(
    input  logic        asleep_i,
    input  sleep_mode_e mode_i,
    input  pad_drv_t    live_i,
    input  pad_drv_t    held_i,
    output pad_drv_t    drv_o
);

    always_comb begin
        if (asleep_i) begin
            drv_o = sleep_drive(mode_i, held_i);
        end else begin
            drv_o = live_i;
        end
    end

endmodule

// File: rtl/pad_sleep_retention.sv
module pad_sleep_retention
    import pad_sleep_pkg::*;
#(
    parameter int unsigned NUM_PADS = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_PADS-1:0] live_dout_i,
    input  logic [NUM_PADS-1:0] live_doe_i,
    input  logic [NUM_PADS-1:0] cfg_wr_i,
    input  logic                cfg_sleep_en_i,
    input  logic [MODE_W-1:0]   cfg_mode_i,
    input  logic [NUM_PADS-1:0] cfg_lock_i,
    input  logic                sleep_trig_i,
    input  logic [NUM_PADS-1:0] sleep_clr_i,
    output logic [NUM_PADS-1:0] pad_dout_o,
    output logic [NUM_PADS-1:0] pad_doe_o,
    output logic [NUM_PADS-1:0] sleep_state_o
);

    pad_sleep_cfg_t                   wdata;
    logic [NUM_PADS-1:0]              cfg_en_q;
    logic [NUM_PADS-1:0][MODE_W-1:0]  cfg_mode_q;
    logic [NUM_PADS-1:0]              cfg_open_q;
    logic [NUM_PADS-1:0]              held_dout;
    logic [NUM_PADS-1:0]              held_doe;

    assign wdata = '{en: cfg_sleep_en_i, mode: sleep_mode_e'(cfg_mode_i)};

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pad_sleep_cfg_t cfg;
        pad_drv_t       live;
        pad_drv_t       held;
        pad_drv_t       drv;
        logic           asleep;

        assign live = '{d: live_dout_i[p], oe: live_doe_i[p]};

        pad_sleep_cfg u_cfg (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .wr_i    (cfg_wr_i[p]),
            .wdata_i (wdata),
            .lock_i  (cfg_lock_i[p]),
            .cfg_o   (cfg),
            .open_o  (cfg_open_q[p])
        );

        pad_sleep_track u_track (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .trig_i   (sleep_trig_i),
            .en_i     (cfg.en),
            .clr_i    (sleep_clr_i[p]),
            .live_i   (live),
            .asleep_o (asleep),
            .held_o   (held)
        );

        pad_sleep_drive u_drive (
            .asleep_i (asleep),
            .mode_i   (cfg.mode),
            .live_i   (live),
            .held_i   (held),
            .drv_o    (drv)
        );

        assign cfg_en_q[p]      = cfg.en;
        assign cfg_mode_q[p]    = cfg.mode;
        assign held_dout[p]     = held.d;
        assign held_doe[p]      = held.oe;
        assign pad_dout_o[p]    = drv.d;
        assign pad_doe_o[p]     = drv.oe;
        assign sleep_state_o[p] = asleep;
    end

endmodule

// File: rtl/pad_sleep_retention_chk.sv
module pad_sleep_retention_chk #(
    parameter int unsigned NUM_PADS = 8
) (
    input logic                      clk_i,
    input logic                      rst_i,
    input logic [NUM_PADS-1:0]       live_dout_i,
    input logic [NUM_PADS-1:0]       live_doe_i,
    input logic                      sleep_trig_i,
    input logic [NUM_PADS-1:0]       sleep_clr_i,
    input logic [NUM_PADS-1:0]       pad_dout_o,
    input logic [NUM_PADS-1:0]       pad_doe_o,
    input logic [NUM_PADS-1:0]       sleep_state_o,
    input logic [NUM_PADS-1:0]       cfg_en_q,
    input logic [NUM_PADS-1:0][1:0]  cfg_mode_q,
    input logic [NUM_PADS-1:0]       cfg_open_q,
    input logic [NUM_PADS-1:0]       held_dout,
    input logic [NUM_PADS-1:0]       held_doe
);

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_chk
        AST_AWAKE_PASSES: assert property (@(posedge clk_i) disable iff (rst_i)
            !sleep_state_o[p] |-> (pad_dout_o[p] == live_dout_i[p] && pad_doe_o[p] == live_doe_i[p])); // R2

        AST_WAKE_ONLY_ON_TRIG: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(sleep_state_o[p]) |-> ($past(sleep_trig_i) && $past(cfg_en_q[p]))); // R7

        AST_STATE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
            (sleep_state_o[p] && !sleep_clr_i[p]) |=> sleep_state_o[p]); // R8

        AST_CLR_WAKES: assert property (@(posedge clk_i) disable iff (rst_i)
            (sleep_state_o[p] && sleep_clr_i[p] && !sleep_trig_i) |=> !sleep_state_o[p]); // R8

        AST_CLR_LOSES_TO_TRIG: assert property (@(posedge clk_i) disable iff (rst_i)
            (sleep_trig_i && cfg_en_q[p] && sleep_clr_i[p]) |=> sleep_state_o[p]); // R9

        AST_HIGHZ_NO_OE: assert property (@(posedge clk_i) disable iff (rst_i)
            (sleep_state_o[p] && cfg_mode_q[p] == 2'd2) |-> !pad_doe_o[p]); // R5

        AST_TIE_LO_DRIVES: assert property (@(posedge clk_i) disable iff (rst_i)
            (sleep_state_o[p] && cfg_mode_q[p] == 2'd0) |-> (pad_doe_o[p] && !pad_dout_o[p])); // R3

        AST_TIE_HI_DRIVES: assert property (@(posedge clk_i) disable iff (rst_i)
            (sleep_state_o[p] && cfg_mode_q[p] == 2'd1) |-> (pad_doe_o[p] && pad_dout_o[p])); // R4

        AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
            (sleep_state_o[p] && $past(sleep_state_o[p])) |-> ($stable(held_dout[p]) && $stable(held_doe[p]))); // R11

        AST_LOCK_FREEZES: assert property (@(posedge clk_i) disable iff (rst_i)
            !cfg_open_q[p] |=> ($stable(cfg_en_q[p]) && $stable(cfg_mode_q[p]) && !cfg_open_q[p])); // R10
    end

endmodule

bind pad_sleep_retention pad_sleep_retention_chk #(.NUM_PADS(NUM_PADS)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .live_dout_i   (live_dout_i),
    .live_doe_i    (live_doe_i),
    .sleep_trig_i  (sleep_trig_i),
    .sleep_clr_i   (sleep_clr_i),
    .pad_dout_o    (pad_dout_o),
    .pad_doe_o     (pad_doe_o),
    .sleep_state_o (sleep_state_o),
    .cfg_en_q      (cfg_en_q),
    .cfg_mode_q    (cfg_mode_q),
    .cfg_open_q    (cfg_open_q),
    .held_dout     (held_dout),
    .held_doe      (held_doe)
);

// File: tb/pad_sleep_retention_tb_top.sv
`timescale 1ns/1ps
module pad_sleep_retention_tb_top;

    localparam int unsigned NP = 5;
    localparam int unsigned WATCHDOG_NS = 100000;

    logic          clk = 1'b0;
    logic          rst_i = 1'b1;
    logic [NP-1:0] live_dout_i = '0;
    logic [NP-1:0] live_doe_i = '0;
    logic [NP-1:0] cfg_wr_i = '0;
    logic          cfg_sleep_en_i = 1'b0;
    logic [1:0]    cfg_mode_i = 2'd0;
    logic [NP-1:0] cfg_lock_i = '0;
    logic          sleep_trig_i = 1'b0;
    logic [NP-1:0] sleep_clr_i = '0;
    logic [NP-1:0] pad_dout_o;
    logic [NP-1:0] pad_doe_o;
    logic [NP-1:0] sleep_state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the requirements
    bit       m_en   [NP];
    bit [1:0] m_mode [NP];
    bit       m_open [NP];
    bit       m_st   [NP];
    bit       m_hd   [NP];
    bit       m_hoe  [NP];

    always #2.5 clk = ~clk;

    pad_sleep_retention #(.NUM_PADS(NP)) dut_i (
        .clk_i          (clk),
        .rst_i          (rst_i),
        .live_dout_i    (live_dout_i),
        .live_doe_i     (live_doe_i),
        .cfg_wr_i       (cfg_wr_i),
        .cfg_sleep_en_i (cfg_sleep_en_i),
        .cfg_mode_i     (cfg_mode_i),
        .cfg_lock_i     (cfg_lock_i),
        .sleep_trig_i   (sleep_trig_i),
        .sleep_clr_i    (sleep_clr_i),
        .pad_dout_o     (pad_dout_o),
        .pad_doe_o      (pad_doe_o),
        .sleep_state_o  (sleep_state_o)
    );

    function automatic bit [1:0] exp_pad(input int i);
        bit [1:0] r; // {d, oe}
        if (!m_st[i]) r = {live_dout_i[i], live_doe_i[i]};
        else begin
            case (m_mode[i])
                2'd0: r = 2'b01;
                2'd1: r = 2'b11;
                2'd2: r = 2'b00;
                default: r = {m_hd[i], m_hoe[i]};
            endcase
        end
        return r;
    endfunction

    task automatic model_edge();
        for (int i = 0; i < NP; i++) begin
            bit old_en, old_st, enter;
            old_en = m_en[i];
            old_st = m_st[i];
            if (rst_i) begin
                m_en[i] = 0; m_mode[i] = 0; m_open[i] = 1; m_st[i] = 0;
                m_hd[i] = 0; m_hoe[i] = 0;
            end else begin
                enter = sleep_trig_i && old_en;
                if (enter && !old_st) begin
                    m_hd[i]  = live_dout_i[i];
                    m_hoe[i] = live_doe_i[i];
                end
                m_st[i] = enter || (old_st && !sleep_clr_i[i]);
                if (cfg_wr_i[i] && m_open[i]) begin
                    m_en[i]   = cfg_sleep_en_i;
                    m_mode[i] = cfg_mode_i;
                end
                if (cfg_lock_i[i]) m_open[i] = 0;
            end
        end
    endtask

    task automatic compare_all(input string tag);
        checks++;
        for (int i = 0; i < NP; i++) begin
            bit [1:0] e;
            e = exp_pad(i);
            if ({pad_dout_o[i], pad_doe_o[i], sleep_state_o[i]} != {e, m_st[i]}) begin
                errors++;
                $display("FAIL %s pad %0d: got d/oe/st=%b%b%b expected %b%b%b", tag, i,
                         pad_dout_o[i], pad_doe_o[i], sleep_state_o[i], e[1], e[0], m_st[i]);
            end
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        compare_all(tag);
    endtask

    task automatic expect_pad(input int i, input bit d, input bit oe, input bit st, input string tag);
        checks++;
        if (pad_dout_o[i] !== d || pad_doe_o[i] !== oe || sleep_state_o[i] !== st) begin
            errors++;
            $display("FAIL %s pad %0d: got d/oe/st=%b%b%b expected %b%b%b", tag, i,
                     pad_dout_o[i], pad_doe_o[i], sleep_state_o[i], d, oe, st);
        end
    endtask

    task automatic write_cfg(input logic [NP-1:0] mask, input bit en, input bit [1:0] mode,
                             input string tag);
        cfg_wr_i = mask; cfg_sleep_en_i = en; cfg_mode_i = mode;
        tick(tag);
        cfg_wr_i = '0;
    endtask

    task automatic pulse_trig(input string tag);
        sleep_trig_i = 1'b1;
        tick(tag);
        sleep_trig_i = 1'b0;
    endtask

    task automatic clear(input logic [NP-1:0] mask, input string tag);
        sleep_clr_i = mask;
        tick(tag);
        sleep_clr_i = '0;
    endtask

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240613));
        #1;
        rst_i = 1'b1;
        live_dout_i = 5'b10110; live_doe_i = 5'b01101;
        for (int k = 0; k < 3; k++) tick("R1 during reset");
        rst_i = 1'b0;
        tick("R1");
        for (int i = 0; i < NP; i++) expect_pad(i, live_dout_i[i], live_doe_i[i], 1'b0, "R1");

        // pad0 low, pad1 high, pad2 high-Z, pad3 hold, pad4 disabled
        write_cfg(5'b00001, 1'b1, 2'd0, "R12");
        write_cfg(5'b00010, 1'b1, 2'd1, "R12");
        write_cfg(5'b00100, 1'b1, 2'd2, "R12");
        write_cfg(5'b01000, 1'b1, 2'd3, "R12");

        live_dout_i = 5'b01010; live_doe_i = 5'b11011;
        pulse_trig("R7");
        expect_pad(0, 1'b0, 1'b1, 1'b1, "R3");
        expect_pad(1, 1'b1, 1'b1, 1'b1, "R4");
        expect_pad(2, 1'b0, 1'b0, 1'b1, "R5");
        expect_pad(3, 1'b1, 1'b1, 1'b1, "R6");
        expect_pad(4, 1'b0, 1'b1, 1'b0, "R2");

        live_dout_i = 5'b10101; live_doe_i = 5'b00100;
        tick("R6");
        expect_pad(3, 1'b1, 1'b1, 1'b1, "R6");
        expect_pad(4, 1'b1, 1'b0, 1'b0, "R2");

        pulse_trig("R11");
        expect_pad(3, 1'b1, 1'b1, 1'b1, "R11");

        clear(5'b00001, "R8");
        expect_pad(0, 1'b1, 1'b0, 1'b0, "R8");
        expect_pad(1, 1'b1, 1'b1, 1'b1, "R8");

        sleep_clr_i = 5'b00010; sleep_trig_i = 1'b1;
        tick("R9");
        sleep_clr_i = '0; sleep_trig_i = 1'b0;
        expect_pad(1, 1'b1, 1'b1, 1'b1, "R9");

        cfg_lock_i = 5'b00100;
        tick("R10");
        cfg_lock_i = '0;
        write_cfg(5'b00100, 1'b0, 2'd3, "R10");
        clear('1, "R10");
        expect_pad(2, live_dout_i[2], live_doe_i[2], 1'b0, "R10");
        pulse_trig("R10");
        expect_pad(2, 1'b0, 1'b0, 1'b1, "R10");

        clear('1, "R12");
        cfg_wr_i = 5'b10000; cfg_sleep_en_i = 1'b1; cfg_mode_i = 2'd1; sleep_trig_i = 1'b1;
        tick("R12");
        cfg_wr_i = '0; sleep_trig_i = 1'b0;
        expect_pad(4, live_dout_i[4], live_doe_i[4], 1'b0, "R12");
        pulse_trig("R12");
        expect_pad(4, 1'b1, 1'b1, 1'b1, "R12");
        clear('1, "R8");

        // random phase with a reset in the middle
        for (int n = 0; n < 3000; n++) begin
            live_dout_i    = NP'($urandom);
            live_doe_i     = NP'($urandom);
            cfg_wr_i       = ($urandom % 4 == 0) ? NP'($urandom) : '0;
            cfg_sleep_en_i = 1'($urandom);
            cfg_mode_i     = 2'($urandom);
            cfg_lock_i     = ($urandom % 64 == 0) ? NP'(1 << ($urandom % NP)) : '0;
            sleep_trig_i   = ($urandom % 8 == 0);
            sleep_clr_i    = ($urandom % 3 == 0) ? NP'($urandom) : '0;
            rst_i          = (n == 1500);
            tick(rst_i ? "R1 random" : "R2-mix random");
        end
        rst_i = 1'b0; cfg_wr_i = '0; cfg_lock_i = '0; sleep_trig_i = 1'b0; sleep_clr_i = '0;
        tick("R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule